// File: doc/BRIEF.md
# Alternating-Tag Reliable Link

This block pairs a transmitting endpoint and a receiving endpoint over two one-frame channel stages. One stage carries data frames forward and the other carries acknowledgements back. Words enter through a valid/ready port and leave through a valid-only port. Each forward frame carries a one-bit tag. The tag flips for every new word. The receiver uses the tag to tell a new word from a repeat. The transmitter keeps re-sending the current word until the receiver acknowledges that word's tag.

Both channel stages can be disturbed from the ports, one cycle at a time. A drop control makes a stage lose the frame it holds. An inject control makes a stage emit a frame that nobody sent, with a tag bit chosen by the caller. Every data bit of an injected frame equals its tag bit. Four observation outputs show what each stage delivers in each cycle.

Retransmission is paced by a reload counter. A frame is re-sent `TIMEOUT` cycles after the previous copy of the same frame.

Top module: `altbit_link`

## Requirements
- R1: After reset `up_rdy` is 1, `dn_vld` is 0, and no frame is delivered on either channel. The first word accepted travels with tag 0.
- R2: Each accepted word carries the inverse of the previous word's tag. The n-th delivered word (counting from 0) is seen with `link_dbit` equal to bit 0 of n.
- R3: While a word is unacknowledged, `up_rdy` stays 0.
- R4: While no matching acknowledgement arrives, the same frame (same tag, same data) is delivered again every `TIMEOUT` cycles (default 16).
- R5: An acknowledgement whose tag differs from the outstanding word's tag is absorbed. `up_rdy` stays 0 and retransmission continues with the same tag.
- R6: A data frame whose tag matches the receiver's expected tag raises `dn_vld` with its data in the same cycle. An acknowledgement with that same tag appears on `link_avld`/`link_abit` one cycle later.
- R7: A data frame whose tag repeats the previously accepted tag does not raise `dn_vld`. Its tag is acknowledged again one cycle later.
- R8: A channel frame present while its `drop_*` input is 1 is not delivered.
- R9: While a stage holds no deliverable frame, `inj_*` = 1 makes it deliver a frame with tag `inj_*_bit` in that cycle.
- R10: Under omission faults alone, every accepted word is delivered exactly once and in order. Accepts and deliveries strictly alternate, and every word arrives within a bounded number of cycles once drops stop.
- R11: Without faults, a word accepted at clock edge n appears on `dn_vld` in the cycle after edge n, and `up_rdy` returns in the cycle after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_vld | input | 1 | Upstream word valid |
| up_data | input | DW | Upstream word |
| up_rdy | output | 1 | Transmitter can take a word |
| dn_vld | output | 1 | New word delivered downstream |
| dn_data | output | DW | Delivered word |
| drop_d | input | 1 | Data stage loses the frame it holds |
| inj_d | input | 1 | Data stage emits a spurious frame |
| inj_d_bit | input | 1 | Tag (and data fill) of the spurious data frame |
| drop_a | input | 1 | Acknowledge stage loses the frame it holds |
| inj_a | input | 1 | Acknowledge stage emits a spurious frame |
| inj_a_bit | input | 1 | Tag of the spurious acknowledgement |
| link_dvld | output | 1 | Data stage delivers a frame this cycle |
| link_dbit | output | 1 | Tag of the delivered data frame |
| link_avld | output | 1 | Acknowledge stage delivers a frame this cycle |
| link_abit | output | 1 | Tag of the delivered acknowledgement |

## Verification
The hardest state to reach is a transmitter that is still waiting while the receiver has already accepted the word. In that state every retransmission is a duplicate, and a foreign acknowledgement can arrive in the middle of the wait. The stimulus holds the acknowledge-stage drop high for several timeout periods. It times the repeated data frames and injects an acknowledgement with the wrong tag halfway between two of them. It then releases the drop and confirms that a single re-acknowledgement frees the transmitter. A vector table then runs words through combined data and acknowledgement drop windows of different lengths. A monitor checks ordering, alternation and uniqueness the whole time.

// File: rtl/altbit_pkg.sv
package altbit_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tx_state_e;

  // next tag in the alternating series
  function automatic logic flip_tag(input logic b);
    return ~b;
  endfunction

  // a frame is present and carries the tag we look for
  function automatic logic tag_hit(input logic vld, input logic got, input logic want);
    return vld && (got == want);
  endfunction

endpackage

// File: rtl/altbit_chan.sv
module altbit_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic         in_bit,
  input  logic [W-1:0] in_data,
  input  logic         drop,
  input  logic         inj,
  input  logic         inj_bit,
  output logic         out_vld,
  output logic         out_bit,
  output logic [W-1:0] out_data
);

  logic         full_q;
  logic         bit_q;
  logic [W-1:0] data_q;
  logic         live;
  logic         spur;

  assign live     = full_q && !drop;
  assign spur     = inj && !live;
  assign out_vld  = live || spur;
  assign out_bit  = live ? bit_q : inj_bit;
  assign out_data = live ? data_q : {W{inj_bit}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      bit_q  <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= in_vld;
      if (in_vld) begin
        bit_q  <= in_bit;
        data_q <= in_data;
      end
    end
  end

  // R9
  no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !inj) |-> $past(in_vld));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !inj) |-> !out_vld);

endmodule

// File: rtl/altbit_tx.sv
module altbit_tx
  import altbit_pkg::*;
#(
  parameter int DW      = 8,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_vld,
  input  logic [DW-1:0] up_data,
  output logic          up_rdy,
  input  logic          ack_vld,
  input  logic          ack_bit,
  output logic          tx_vld,
  output logic          tx_bit,
  output logic [DW-1:0] tx_data
);

  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] RELOAD = TW'(TIMEOUT - 1);

  tx_state_e     state_q;
  logic          seq_q;
  logic [DW-1:0] hold_q;
  logic [TW-1:0] tmr_q;

  logic waiting;
  logic up_fire;
  logic ack_hit;
  logic expire;

  assign waiting = (state_q == ST_WAIT);
  assign up_rdy  = !waiting;
  assign up_fire = up_vld && up_rdy;
  assign ack_hit = waiting && tag_hit(ack_vld, ack_bit, seq_q);
  assign expire  = waiting && !ack_hit && (tmr_q == '0);
  assign tx_vld  = up_fire || expire;
  assign tx_bit  = seq_q;
  assign tx_data = up_fire ? up_data : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seq_q   <= 1'b0;
      hold_q  <= '0;
      tmr_q   <= '0;
    end else if (up_fire) begin
      state_q <= ST_WAIT;
      hold_q  <= up_data;
      tmr_q   <= RELOAD;
    end else if (ack_hit) begin
      state_q <= ST_IDLE;
      seq_q   <= flip_tag(seq_q);
    end else if (expire) begin
      tmr_q   <= RELOAD;
    end else if (waiting) begin
      tmr_q   <= tmr_q - 1'b1;
    end
  end

  // cycles since the last frame left, for the pacing check
  logic [TW:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= '0;
    else if (tx_vld)  gap_q <= '0;
    else if (waiting) gap_q <= gap_q + 1'b1;
  end

  // R2
  tag_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_q != $past(seq_q)) |-> $past(ack_hit));

  // R4
  resend_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (gap_q < (TW+1)'(TIMEOUT)));

  // R5
  foreign_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && ack_vld && !ack_hit) |=> (!up_rdy && $stable(seq_q)));

  // R3
  held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && $past(waiting)) |-> $stable(hold_q));

endmodule

// File: rtl/altbit_rx.sv
module altbit_rx
  import altbit_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_vld,
  input  logic          frm_bit,
  input  logic [DW-1:0] frm_data,
  output logic          dn_vld,
  output logic [DW-1:0] dn_data,
  output logic          ack_snd,
  output logic          ack_sbit
);

  logic exp_q;
  logic fresh;

  assign fresh    = tag_hit(frm_vld, frm_bit, exp_q);
  assign dn_vld   = fresh;
  assign dn_data  = frm_data;
  assign ack_snd  = frm_vld;
  assign ack_sbit = frm_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     exp_q <= 1'b0;
    else if (fresh) exp_q <= flip_tag(exp_q);
  end

  // R6
  accept_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_vld |=> (exp_q != $past(exp_q)));

  // R7
  repeat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && !dn_vld) |=> $stable(exp_q));

endmodule

// File: rtl/altbit_link.sv
module altbit_link #(
  parameter int DW      = 8,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_vld,
  input  logic [DW-1:0] up_data,
  output logic          up_rdy,
  output logic          dn_vld,
  output logic [DW-1:0] dn_data,
  input  logic          drop_d,
  input  logic          inj_d,
  input  logic          inj_d_bit,
  input  logic          drop_a,
  input  logic          inj_a,
  input  logic          inj_a_bit,
  output logic          link_dvld,
  output logic          link_dbit,
  output logic          link_avld,
  output logic          link_abit
);

  logic          tx_vld, tx_bit;
  logic [DW-1:0] tx_data;
  logic [DW-1:0] frm_data;
  logic          ack_snd, ack_sbit;
  logic          ach_bit;
  logic [0:0]    ach_data;

  altbit_tx #(.DW(DW), .TIMEOUT(TIMEOUT)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .up_vld(up_vld), .up_data(up_data), .up_rdy(up_rdy),
    .ack_vld(link_avld), .ack_bit(ach_bit),
    .tx_vld(tx_vld), .tx_bit(tx_bit), .tx_data(tx_data)
  );

  altbit_chan #(.W(DW)) u_dch (
    .clk(clk), .rst_n(rst_n),
    .in_vld(tx_vld), .in_bit(tx_bit), .in_data(tx_data),
    .drop(drop_d), .inj(inj_d), .inj_bit(inj_d_bit),
    .out_vld(link_dvld), .out_bit(link_dbit), .out_data(frm_data)
  );

  altbit_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .frm_vld(link_dvld), .frm_bit(link_dbit), .frm_data(frm_data),
    .dn_vld(dn_vld), .dn_data(dn_data),
    .ack_snd(ack_snd), .ack_sbit(ack_sbit)
  );

  altbit_chan #(.W(1)) u_ach (
    .clk(clk), .rst_n(rst_n),
    .in_vld(ack_snd), .in_bit(ack_sbit), .in_data(ack_sbit),
    .drop(drop_a), .inj(inj_a), .inj_bit(inj_a_bit),
    .out_vld(link_avld), .out_bit(ach_bit), .out_data(ach_data)
  );

  assign link_abit = ach_data[0];

  // R10
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dn_vld && up_vld && up_rdy && !inj_d));

endmodule

// File: tb/test_altbit_link.sv
`timescale 1ns/1ps
module test_altbit_link;

  localparam int DW = 8;
  localparam int TO = 16;
  localparam int NV = 8;
  // {data[15:8], data-drop window in units of 8 cycles[7:4], ack-drop window[3:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'hA1_00, 16'h3C_10, 16'hF0_30, 16'h0F_02,
    16'h96_22, 16'h5A_51, 16'hC3_04, 16'h77_43
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_vld = 1'b0;
  logic [DW-1:0] up_data = '0;
  logic up_rdy, dn_vld;
  logic [DW-1:0] dn_data;
  logic drop_d = 0, inj_d = 0, inj_d_bit = 0, drop_a = 0, inj_a = 0, inj_a_bit = 0;
  logic link_dvld, link_dbit, link_avld, link_abit;

  always #2.5 clk = ~clk;

  altbit_link #(.DW(DW), .TIMEOUT(TO)) i_altbit_link (
    .clk(clk), .rst_n(rst_n), .up_vld(up_vld), .up_data(up_data), .up_rdy(up_rdy),
    .dn_vld(dn_vld), .dn_data(dn_data),
    .drop_d(drop_d), .inj_d(inj_d), .inj_d_bit(inj_d_bit),
    .drop_a(drop_a), .inj_a(inj_a), .inj_a_bit(inj_a_bit),
    .link_dvld(link_dvld), .link_dbit(link_dbit),
    .link_avld(link_avld), .link_abit(link_abit)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int acc_n = 0;
  int del_n = 0;
  int cyc = 0;
  logic [DW-1:0] sent_q [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // step to just after the next rising edge, then let inputs settle
  task automatic next();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #0.5;
  endtask

  // scoreboard: order, uniqueness, alternation (R2, R10)
  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      if (up_vld && up_rdy) begin
        chk(acc_n == del_n, "R10 accept only after previous delivery", acc_n, del_n);
        sent_q[acc_n[5:0]] = up_data;
        acc_n++;
      end
      if (dn_vld) begin
        chk(del_n < acc_n, "R10 no duplicate delivery", del_n, acc_n);
        chk(dn_data == sent_q[del_n[5:0]], "R10 in-order data", dn_data, sent_q[del_n[5:0]]);
        chk(link_dbit == del_n[0], "R2 alternating tag", link_dbit, del_n[0]);
        del_n++;
      end
      if (cyc > 100000) begin
        chk(1'b0, "watchdog", cyc, 100000);
        wrap_up();
      end
    end
  end

  initial begin
    int waited;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    next(); settle();
    chk(up_rdy == 1'b1, "R1 up_rdy after reset", up_rdy, 1);
    chk(dn_vld == 1'b0, "R1 dn_vld after reset", dn_vld, 0);
    chk(link_dvld == 1'b0 && link_avld == 1'b0, "R1 channels idle", link_dvld, 0);

    // fault-free word, latency
    up_vld = 1; up_data = 8'h5A; settle();
    chk(up_rdy == 1'b1, "R11 ready before accept", up_rdy, 1);
    next(); up_vld = 0; settle();
    chk(dn_vld == 1'b1 && dn_data == 8'h5A, "R6 R11 delivery next cycle", dn_data, 8'h5A);
    chk(link_dbit == 1'b0, "R1 first tag is 0", link_dbit, 0);
    next(); settle();
    chk(link_avld == 1'b1 && link_abit == 1'b0, "R6 ack echoes tag", link_abit, 0);
    chk(up_rdy == 1'b0, "R3 busy while unacknowledged", up_rdy, 0);
    next(); settle();
    chk(up_rdy == 1'b1, "R11 ready two cycles after delivery", up_rdy, 1);

    // spurious repeat-tag data frame: receiver now expects 1
    inj_d = 1; inj_d_bit = 0; settle();
    chk(link_dvld == 1'b1 && link_dbit == 1'b0, "R9 spurious data frame", link_dbit, 0);
    chk(dn_vld == 1'b0, "R7 repeat tag not delivered", dn_vld, 0);
    next(); inj_d = 0; settle();
    chk(link_avld == 1'b1 && link_abit == 1'b0, "R7 repeat tag re-acknowledged", link_abit, 0);
    chk(up_rdy == 1'b1, "R5 idle sender ignores ack", up_rdy, 1);

    // acks lost: retransmission pacing, duplicate suppression, foreign ack
    drop_a = 1; up_vld = 1; up_data = 8'h33;
    next(); up_vld = 0;
    for (int k = 1; k <= 40; k++) begin
      if (k == 10) begin inj_a = 1; inj_a_bit = 0; end
      if (k == 11) inj_a = 0;
      settle();
      chk(link_dvld == ((k == 1) || (k == 1 + TO) || (k == 1 + 2*TO)),
          "R4 retransmit period", link_dvld, (k == 1) || (k == 1 + TO) || (k == 1 + 2*TO));
      if (link_dvld) chk(link_dbit == 1'b1, "R5 tag unchanged on resend", link_dbit, 1);
      chk(dn_vld == (k == 1), "R7 only first copy delivered", dn_vld, k == 1);
      if (k == 10) chk(link_avld == 1'b1 && link_abit == 1'b0, "R9 spurious ack", link_abit, 0);
      if (k != 10) chk(link_avld == 1'b0, "R8 ack dropped", link_avld, 0);
      if (k == 11) chk(up_rdy == 1'b0, "R5 foreign ack absorbed", up_rdy, 0);
      if (k < 40) next();
    end
    drop_a = 0;
    waited = 0;
    while (!up_rdy && waited < 100) begin next(); settle(); waited++; end
    chk(up_rdy == 1'b1, "R7 re-ack releases sender", up_rdy, 1);
    chk(waited <= 2*TO, "R4 release bound", waited, 2*TO);
    chk(del_n == 2, "R7 single delivery of retried word", del_n, 2);

    // vector table under omission faults
    for (int v = 0; v < NV; v++) begin
      next();
      up_vld = 1; up_data = VEC[v][15:8];
      drop_d = (VEC[v][7:4] != 0); drop_a = (VEC[v][3:0] != 0);
      next(); up_vld = 0;
      base = 0;
      settle();
      chk(link_dvld == (VEC[v][7:4] == 0), "R8 data frame dropped", link_dvld, VEC[v][7:4] == 0);
      waited = 0;
      while (waited < 400 && !(up_rdy && waited >= 2)) begin
        if (waited >= 8 * int'(VEC[v][7:4])) drop_d = 0;
        if (waited >= 8 * int'(VEC[v][3:0])) drop_a = 0;
        next(); settle(); waited++;
      end
      drop_d = 0; drop_a = 0;
      chk(up_rdy == 1'b1, "R10 bounded delivery", waited, 400);
      chk(del_n == acc_n, "R10 one output per input", del_n, acc_n);
    end
    next();
    chk(del_n == NV + 2, "R10 total deliveries", del_n, NV + 2);
    wrap_up();
  end

endmodule